// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip: a serial four-wire port (test clock, mode select, data in, data out) plus an optional active-low asynchronous reset. A sixteen-state controller, stepped by the mode-select line on each rising test-clock edge, sequences a 10-bit instruction register and a set of data registers. The instruction that is current chooses which data register sits between the serial input and the serial output. The candidates are a one-bit bypass cell, a fixed 32-bit identification word, a 32-bit user word taken from an input port, or an external boundary-scan chain. The chain itself and the pads are not part of this block. For the chain the block provides capture, shift and update strobes and a serial input, and it accepts the chain's serial output.

Two latched controls leave the block. `bscan_mode` tells the pad ring to drive pins from the scan cells during the external-test instruction. `io_hiz` floats every I/O while the float instruction is current. Both change only when a new instruction is committed, and both clear on any reset of the controller.

Controller states and transitions (mode-select value in brackets):
- ST_RESET stays on [1] and goes to ST_IDLE on [0].
- ST_IDLE goes to ST_SEL_DR on [1] and stays on [0].
- ST_SEL_DR goes to ST_SEL_IR on [1] and to ST_CAP_DR on [0].
- ST_CAP_DR and ST_SH_DR go to ST_EX1_DR on [1] and to ST_SH_DR on [0].
- ST_EX1_DR goes to ST_UPD_DR on [1] and to ST_PAU_DR on [0].
- ST_PAU_DR goes to ST_EX2_DR on [1] and stays on [0].
- ST_EX2_DR goes to ST_UPD_DR on [1] and back to ST_SH_DR on [0].
- ST_UPD_DR goes to ST_SEL_DR on [1] and to ST_IDLE on [0].
- ST_SEL_IR goes to ST_RESET on [1] and to ST_CAP_IR on [0].
- The instruction-side states (ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR) mirror the data-side states exactly.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The controller holds one of sixteen states, samples `tms` on rising `tck`, and follows exactly the transitions listed above.
- R2: While `trst_n` is low, and at the rising `tck` edge that enters ST_RESET, the current instruction becomes 0x006 and both latched controls clear. Any state reaches ST_RESET after five rising edges with `tms` high.
- R3: On leaving ST_CAP_IR the instruction shift register loads 10'b00_0000_0001. In ST_SH_IR it shifts LSB first toward `tdo`, and `tdi` enters at bit 9.
- R4: The current instruction changes only at the rising edge that leaves ST_UPD_IR (apart from R2). Shifting, pausing or exiting leaves `bscan_mode`, `io_hiz` and the selected register unchanged.
- R5: Opcode 0x006 selects the 32-bit identification register. It captures parameter `ID_VALUE` and shifts it out LSB first.
- R6: Opcode 0x007 selects the 32-bit user register. It captures `usercode_i` and shifts it out LSB first.
- R7: Opcode 0x3FF, and every opcode not named in R5, R6, R8 or R9, selects the one-bit bypass cell. That cell captures 0 and delays `tdi` by one shift.
- R8: Opcodes 0x000 and 0x005 select the external chain. `chain_capture`, `chain_shift` and `chain_update` are high only in ST_CAP_DR, ST_SH_DR and ST_UPD_DR respectively, and only while the chain is selected. `chain_si` follows `tdi`, and `tdo` carries `chain_so`.
- R9: `bscan_mode` is 1 exactly while 0x000 is current, and `io_hiz` is 1 exactly while 0x00B is current. Opcode 0x00B routes data through the bypass cell.
- R10: `tdo` and `tdo_oe` change on falling `tck`. `tdo_oe` is 1 only after a falling edge seen in ST_SH_DR or ST_SH_IR, and that edge presents the LSB of the selected register on `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low controller reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| usercode_i | input | 32 | Word captured by the user-code instruction |
| chain_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| bscan_mode | output | 1 | Pins driven from scan cells (external test) |
| io_hiz | output | 1 | Float all I/O pins |
| chain_capture | output | 1 | Boundary chain capture strobe |
| chain_shift | output | 1 | Boundary chain shift enable |
| chain_update | output | 1 | Boundary chain update strobe |
| chain_si | output | 1 | Serial input to the boundary chain |

## Verification
Each captured bit appears on `tdo` half a clock after the rising edge that enters a shift state, and each later bit appears half a clock after the rising edge that shifts it. The bench therefore drives `tms` and `tdi` while the clock is low and reads `tdo` and `tdo_oe` just after the following falling edge. A committed instruction affects `bscan_mode`, `io_hiz` and the register selection from the rising edge that leaves ST_UPD_IR, so those outputs are read one full step later, in ST_IDLE. The asynchronous reset is checked within the same clock-low phase in which it is applied. The fifth consecutive `tms`-high edge is checked immediately after that edge, with the fourth checked as well to show the controls still held.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    parameter int unsigned IR_LEN = 10;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_USER, DR_CHAIN
    } dr_sel_e;

    localparam logic [IR_LEN-1:0] OP_EXTEST   = 10'h000;
    localparam logic [IR_LEN-1:0] OP_SAMPLE   = 10'h005;
    localparam logic [IR_LEN-1:0] OP_IDCODE   = 10'h006;
    localparam logic [IR_LEN-1:0] OP_USERCODE = 10'h007;
    localparam logic [IR_LEN-1:0] OP_HIGHZ    = 10'h00B;
    localparam logic [IR_LEN-1:0] OP_BYPASS   = {IR_LEN{1'b1}};
    localparam logic [IR_LEN-1:0] IR_CAPTURE  = {{(IR_LEN-2){1'b0}}, 2'b01};

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_nx
);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RESET:  state_nx = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_nx = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_nx;
    end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_e        state_q,
    input  tap_state_e        state_nx,
    output logic [IR_LEN-1:0] ir_sr,
    output logic [IR_LEN-1:0] ir_q,
    output dr_sel_e           dr_sel,
    output logic              ext_mode,
    output logic              hiz_mode
);

    // Shift stage: capture fixed pattern, shift toward bit 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= IR_CAPTURE;
        end else if (state_q == ST_CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state_q == ST_SH_IR) begin
            ir_sr <= {tdi, ir_sr[IR_LEN-1:1]};
        end
    end

    // Current instruction: identification on reset entry, commit on update.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_q <= OP_IDCODE;
        end else if (state_nx == ST_RESET) begin
            ir_q <= OP_IDCODE;
        end else if (state_q == ST_UPD_IR) begin
            ir_q <= ir_sr;
        end
    end

    always_comb begin
        case (ir_q)
            OP_IDCODE:          dr_sel = DR_IDENT;
            OP_USERCODE:        dr_sel = DR_USER;
            OP_EXTEST,
            OP_SAMPLE:          dr_sel = DR_CHAIN;
            default:            dr_sel = DR_BYPASS;
        endcase
    end

    assign ext_mode = (ir_q == OP_EXTEST);
    assign hiz_mode = (ir_q == OP_HIGHZ);

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int unsigned          WORD_W   = 32,
    parameter logic [WORD_W-1:0]    ID_VALUE = 32'h149A_603D
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_e        state_q,
    input  dr_sel_e           dr_sel,
    input  logic [WORD_W-1:0] usercode_i,
    input  logic              chain_so,
    output logic              dr_tdo
);

    logic              byp_q;
    logic [WORD_W-1:0] word_sr;
    logic              word_sel;

    assign word_sel = (dr_sel == DR_IDENT) || (dr_sel == DR_USER);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (dr_sel == DR_BYPASS) begin
            if (state_q == ST_CAP_DR)     byp_q <= 1'b0;
            else if (state_q == ST_SH_DR) byp_q <= tdi;
        end
    end

    // One shared word register serves both identification and user code.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            word_sr <= '0;
        end else if (word_sel) begin
            if (state_q == ST_CAP_DR)
                word_sr <= (dr_sel == DR_IDENT) ? ID_VALUE : usercode_i;
            else if (state_q == ST_SH_DR)
                word_sr <= {tdi, word_sr[WORD_W-1:1]};
        end
    end

    always_comb begin
        unique case (dr_sel)
            DR_BYPASS: dr_tdo = byp_q;
            DR_IDENT,
            DR_USER:   dr_tdo = word_sr[0];
            DR_CHAIN:  dr_tdo = chain_so;
        endcase
    end

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import jtag_tap_pkg::*;
#(
    parameter int unsigned       WORD_W   = 32,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h149A_603D
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [WORD_W-1:0] usercode_i,
    input  logic              chain_so,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              bscan_mode,
    output logic              io_hiz,
    output logic              chain_capture,
    output logic              chain_shift,
    output logic              chain_update,
    output logic              chain_si
);

    tap_state_e        state_q;
    tap_state_e        state_nx;
    logic [IR_LEN-1:0] ir_sr;
    logic [IR_LEN-1:0] ir_q;
    dr_sel_e           dr_sel;
    logic              ext_mode;
    logic              hiz_mode;
    logic              dr_tdo;
    logic              chain_on;

    jtag_tap_fsm u_fsm (
        .tck      (tck),
        .trst_n   (trst_n),
        .tms      (tms),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    jtag_tap_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state_q  (state_q),
        .state_nx (state_nx),
        .ir_sr    (ir_sr),
        .ir_q     (ir_q),
        .dr_sel   (dr_sel),
        .ext_mode (ext_mode),
        .hiz_mode (hiz_mode)
    );

    jtag_tap_dr #(
        .WORD_W   (WORD_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_q    (state_q),
        .dr_sel     (dr_sel),
        .usercode_i (usercode_i),
        .chain_so   (chain_so),
        .dr_tdo     (dr_tdo)
    );

    assign chain_on      = (dr_sel == DR_CHAIN);
    assign chain_capture = chain_on && (state_q == ST_CAP_DR);
    assign chain_shift   = chain_on && (state_q == ST_SH_DR);
    assign chain_update  = chain_on && (state_q == ST_UPD_DR);
    assign chain_si      = tdi;
    assign bscan_mode    = ext_mode;
    assign io_hiz        = hiz_mode;

    // Output stage retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state_q == ST_SH_IR) ? ir_sr[0] : dr_tdo;
            tdo_oe <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
        end
    end

endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
    import jtag_tap_pkg::*;
(
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input tap_state_e        state_q,
    input tap_state_e        state_nx,
    input logic [IR_LEN-1:0] ir_sr,
    input logic [IR_LEN-1:0] ir_q,
    input logic              tdo_oe,
    input logic              bscan_mode,
    input logic              io_hiz,
    input logic              chain_capture,
    input logic              chain_shift,
    input logic              chain_update
);

    logic [2:0] ones_cnt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)              ones_cnt <= 3'd0;
        else if (!tms)            ones_cnt <= 3'd0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_cnt == 3'd5) |-> (state_q == ST_RESET));

    p_reset_ident_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |-> (ir_q == OP_IDCODE && !bscan_mode && !io_hiz));

    p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));

    p_ir_hold_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q != ST_UPD_IR && state_nx != ST_RESET) |=> $stable(ir_q));

    p_strobe_excl_r8: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({chain_capture, chain_shift, chain_update}));

    p_mode_excl_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !(bscan_mode && io_hiz));

    p_oe_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state_q == ST_SH_DR || state_q == ST_SH_IR));

endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
    .tck           (tck),
    .trst_n        (trst_n),
    .tms           (tms),
    .state_q       (state_q),
    .state_nx      (state_nx),
    .ir_sr         (ir_sr),
    .ir_q          (ir_q),
    .tdo_oe        (tdo_oe),
    .bscan_mode    (bscan_mode),
    .io_hiz        (io_hiz),
    .chain_capture (chain_capture),
    .chain_shift   (chain_shift),
    .chain_update  (chain_update)
);

// File: tb/jtag_tap_ctrl_test.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_test;

    localparam logic [31:0] BENCH_ID = 32'h149A_603D;
    localparam logic [31:0] BENCH_UC = 32'hC0DE_F0B2;
    localparam logic [7:0]  CHAIN_PAT = 8'h3C;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [31:0] usercode_i = BENCH_UC;
    logic chain_so;
    logic tdo, tdo_oe, bscan_mode, io_hiz;
    logic chain_capture, chain_shift, chain_update, chain_si;

    int checks = 0;
    int errors = 0;
    int upd_cnt = 0;
    bit done = 0;
    logic [7:0] chain_reg = 8'h00;

    always #2.5 tck = ~tck;

    jtag_tap_ctrl #(.WORD_W(32), .ID_VALUE(BENCH_ID)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .usercode_i(usercode_i), .chain_so(chain_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bscan_mode(bscan_mode), .io_hiz(io_hiz),
        .chain_capture(chain_capture), .chain_shift(chain_shift),
        .chain_update(chain_update), .chain_si(chain_si)
    );

    // Behavioural model of an external 8-cell boundary chain.
    always @(posedge tck) begin
        if (chain_capture)    chain_reg <= CHAIN_PAT;
        else if (chain_shift) chain_reg <= {chain_si, chain_reg[7:1]};
        if (chain_update)     upd_cnt <= upd_cnt + 1;
    end
    assign chain_so = chain_reg[0];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive during clock-low, step one rising edge, settle after the falling edge.
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // From ST_IDLE: shift op in, return captured bits, end in ST_IDLE.
    task automatic load_ir(input logic [9:0] op, output logic [9:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 10; i++) begin
            cap[i] = tdo;
            tick(i == 9, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // From ST_IDLE: read n bits (tdi held at d), end in ST_IDLE.
    task automatic read_dr(input int n, input logic d, output logic [31:0] val, output bit oe_ok);
        val = '0;
        oe_ok = 1;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            val[i] = tdo;
            if (tdo_oe !== 1'b1) oe_ok = 0;
            tick(i == n - 1, d);
        end
        if (tdo_oe !== 1'b0) oe_ok = 0;
        tick(1, 0); tick(0, 0);
    endtask

    function automatic logic [3:0] expect4(input logic [9:0] op);
        case (op)
            10'h006:          return BENCH_ID[3:0];
            10'h007:          return BENCH_UC[3:0];
            10'h000, 10'h005: return CHAIN_PAT[3:0];
            default:          return 4'hE;
        endcase
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0]  cap;
        logic [31:0] val;
        bit          oe_ok;
        int          u0;

        @(negedge tck); #1;
        check(tdo_oe === 1'b0 && bscan_mode === 1'b0 && io_hiz === 1'b0,
              "R2 reset outputs", {tdo_oe, bscan_mode, io_hiz}, 0);
        trst_n = 1'b1;
        tick(1, 0);
        tick(0, 0);

        // R5: default instruction after reset is identification.
        read_dr(32, 0, val, oe_ok);
        check(val === BENCH_ID, "R5 idcode after reset", val, BENCH_ID);
        check(oe_ok, "R10 oe during shift only", oe_ok, 1);

        // R6 with a pause in the middle (R1 pause and exit2 paths).
        load_ir(10'h007, cap);
        check(cap === 10'h001, "R3 ir capture", cap, 10'h001);
        tick(1, 0); tick(0, 0); tick(0, 0);
        val = '0;
        for (int i = 0; i < 16; i++) begin val[i] = tdo; tick(i == 15, 0); end
        tick(0, 0);
        check(tdo_oe === 1'b0, "R10 oe low in pause", tdo_oe, 0);
        tick(0, 0); tick(1, 0); tick(0, 0);
        for (int i = 16; i < 32; i++) begin val[i] = tdo; tick(i == 31, 0); end
        tick(1, 0); tick(0, 0);
        check(val === BENCH_UC, "R1 R6 usercode with pause", val, BENCH_UC);

        // Sweep every opcode.
        for (int op = 0; op < 1024; op++) begin
            load_ir(op[9:0], cap);
            check(cap === 10'h001, "R3 ir capture sweep", cap, 10'h001);
            check(bscan_mode === (op == 0) && io_hiz === (op == 11),
                  "R9 latched modes", {bscan_mode, io_hiz}, {(op == 0), (op == 11)});
            u0 = upd_cnt;
            read_dr(4, 1, val, oe_ok);
            check(val[3:0] === expect4(op[9:0]), "R5 R6 R7 R8 dr select", val[3:0], expect4(op[9:0]));
            check(oe_ok, "R10 oe window", oe_ok, 1);
            check((upd_cnt - u0) == ((op == 0 || op == 5) ? 1 : 0), "R8 chain update strobe",
                  upd_cnt - u0, (op == 0 || op == 5) ? 1 : 0);
        end

        // R8: chain receives tdi serially.
        load_ir(10'h005, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 8; i++) tick(i == 7, 8'h96 >> i);
        tick(1, 0); tick(0, 0);
        check(chain_reg === 8'h96, "R8 chain serial in", chain_reg, 8'h96);

        // R4: a new instruction waits for update.
        load_ir(10'h000, cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 10; i++) tick(i == 9, 10'h00B >> i);
        check(bscan_mode === 1'b1 && io_hiz === 1'b0, "R4 hold in exit1", {bscan_mode, io_hiz}, 2'b10);
        tick(0, 0);
        tick(1, 0);
        tick(1, 0);
        check(bscan_mode === 1'b1 && io_hiz === 1'b0, "R4 hold in update", {bscan_mode, io_hiz}, 2'b10);
        tick(0, 0);
        check(bscan_mode === 1'b0 && io_hiz === 1'b1, "R4 R9 commit", {bscan_mode, io_hiz}, 2'b01);

        // R2: five tms-high edges from shift-dr.
        load_ir(10'h000, cap);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(1, 0);
        check(bscan_mode === 1'b1, "R2 still held after four", bscan_mode, 1);
        tick(1, 0);
        check(bscan_mode === 1'b0 && tdo_oe === 1'b0, "R2 reset after five", {bscan_mode, tdo_oe}, 0);
        tick(0, 0);

        // R2: asynchronous reset.
        load_ir(10'h00B, cap);
        check(io_hiz === 1'b1, "R9 float set", io_hiz, 1);
        trst_n = 1'b0;
        #1;
        check(io_hiz === 1'b0 && bscan_mode === 1'b0, "R2 async reset", {io_hiz, bscan_mode}, 0);
        #0.5;
        trst_n = 1'b1;
        tick(0, 0);
        read_dr(4, 0, val, oe_ok);
        check(val[3:0] === BENCH_ID[3:0], "R2 identification after async reset", val[3:0], BENCH_ID[3:0]);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule